// File: doc/BRIEF.md
# Sleep, Wake-up and Reset Sequencer

This block sequences power-down and reset for a small microcontroller core. The instruction decoder asks for sleep with a one-cycle halt request. While the core sleeps, the block watches for four wake causes: the external reset pin, a watchdog overflow, a fresh interrupt request, and a falling edge on any wake-enabled pin of an 8-bit port. On each wake it holds the core in a start-up delay of 1024 clocks. It then issues exactly one outcome strobe: a cold reset, a warm reset (program counter and stack pointer only), a plain resume at the next instruction, or an interrupt vector.

Two status flags record why the core restarted. The time-out flag is set by the watchdog. The power-down flag is set by sleep entry and cleared by the clear-watchdog pulse. The power-up reset `rstN` clears both flags and also applies the start-up delay. An external reset or watchdog overflow during normal run gives an immediate cold-reset strobe with no delay. While the core sleeps, an output disables external program memory. On sleep entry the block pulses a restart request to the watchdog counter, which lies outside this block. The external reset input is taken as a clean synchronous pulse.

Top module: `sleep_wake_top`

## Requirements
- R1: After power-up reset (`rstN` low), toFlag=0 and pdFlag=0. After `rstN` is released, holdStartup stays high for exactly 1024 clocks and coldRst pulses in the clock right after.
- R2: A haltReq taken during run enters sleep. From the next cycle pdFlag=1, toFlag=0 and extMemOff=1. wdtRestart is high for that one cycle only, and extMemOff stays high until a wake.
- R3: A wdtClr pulse during run with no higher-priority event clears pdFlag and leaves toFlag unchanged.
- R4: extRst during run gives a coldRst pulse in the next cycle, with no start-up hold, and leaves both flags unchanged.
- R5: wdtOvf during run gives a coldRst pulse in the next cycle, with no start-up hold. It sets toFlag and leaves pdFlag unchanged.
- R6: extRst during sleep gives the 1024-clock hold followed by coldRst, with toFlag=0 and pdFlag=1.
- R7: wdtOvf during sleep gives the 1024-clock hold followed by warmRst, with toFlag=1 and pdFlag=1.
- R8: Port pins pass through a two-stage synchronizer. A 1-to-0 transition on pin i wakes the core only when wakeMask[i]=1, and then gives the hold followed by resumeNext. A falling edge on a pin whose mask bit is 0 leaves the core asleep.
- R9: An interrupt wake gives resumeNext in the clock right after the hold when the waking request's enable is 0 or stackFull=1. Otherwise it gives vectorIrq one clock later than that, with no resume strobe.
- R10: An irqReq bit that is already 1 when sleep is entered cannot wake the core.
- R11: Wake causes arriving together are ranked external reset, then watchdog, then interrupt, then port.
- R12: At most one of coldRst, warmRst, resumeNext and vectorIrq is high in any cycle, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-up reset, active low, asynchronous |
| haltReq | input | 1 | Sleep request from the decoder, one cycle |
| wdtClr | input | 1 | Clear-watchdog pulse from the decoder |
| extRst | input | 1 | External reset pin, synchronous, active high |
| wdtOvf | input | 1 | Watchdog overflow pulse |
| irqReq | input | IRQ_N (2) | Interrupt request flags |
| irqEn | input | IRQ_N (2) | Per-interrupt enables |
| stackFull | input | 1 | Return stack has no free entry |
| portIn | input | PORT_W (8) | Wake-capable port pins, asynchronous |
| wakeMask | input | PORT_W (8) | Per-pin wake enable |
| toFlag | output | 1 | Watchdog time-out status |
| pdFlag | output | 1 | Power-down status |
| coldRst | output | 1 | Full reset strobe |
| warmRst | output | 1 | Program counter and stack pointer reset strobe |
| holdStartup | output | 1 | Start-up delay in progress, core held |
| resumeNext | output | 1 | Continue at the next instruction |
| vectorIrq | output | 1 | Take the interrupt vector |
| extMemOff | output | 1 | External program memory disable, high while asleep |
| wdtRestart | output | 1 | Clear and restart the watchdog counter |

## Verification
The wake path is driven by each single cause in turn. The sleep-time reset and the watchdog wake can only be told apart by the strobe kind and the flag pair. The port and interrupt wakes are told apart by the gap between the end of the hold and the strobe, and by whether the strobe is a resume or a vector. Masked pins and requests already pending at sleep entry are applied and the core is shown to stay asleep. Stacked causes in one cycle show the ranking, because each winner gives a different strobe or flag pair. Events during run show that the hold is skipped and which flag each cause touches.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;

  typedef enum logic [2:0] {
    ST_RUN, ST_SLEEP, ST_HOLD, ST_ISSUE, ST_VECT
  } seqState_t;

  typedef enum logic [1:0] {
    CAUSE_COLD, CAUSE_WARM, CAUSE_RESUME, CAUSE_VECTOR
  } wakeCause_t;

  // strobes from control to datapath
  typedef struct packed {
    logic enterHalt;   // sleep entry: flags and interrupt arming
    logic clrPdf;      // clear-watchdog in run
    logic wdtRunHit;   // watchdog overflow in run
    logic extSleepHit; // external reset while asleep
    logic wdtSleepHit; // watchdog wake while asleep
    logic loadHold;    // start the start-up delay
    logic decHold;     // count the delay down
  } dpCtl_t;

endpackage

// File: rtl/sleep_wake_dp.sv
module sleep_wake_dp
  import sleep_wake_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int IRQ_N    = 2,
  parameter int HOLD_CYC = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [IRQ_N-1:0]  irqReq,
  input  logic [IRQ_N-1:0]  irqEn,
  input  logic              stackFull,
  input  logic [PORT_W-1:0] portIn,
  input  logic [PORT_W-1:0] wakeMask,
  output logic              portWake,
  output logic              irqWake,
  output logic              vecOk,
  output logic              holdDone,
  output logic              toFlag,
  output logic              pdFlag
);

  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);

  // per-pin synchronizer and falling-edge detect
  logic [PORT_W-1:0] pinFall;
  genvar gi;
  generate
    for (gi = 0; gi < PORT_W; gi++) begin : g_pin
      logic meta, syncd, prevSyncd;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          meta      <= 1'b1;
          syncd     <= 1'b1;
          prevSyncd <= 1'b1;
        end else begin
          meta      <= portIn[gi];
          syncd     <= meta;
          prevSyncd <= syncd;
        end
      end
      assign pinFall[gi] = prevSyncd & ~syncd & wakeMask[gi];
    end
  endgenerate
  assign portWake = |pinFall;

  // interrupts pending at sleep entry are excluded from waking
  logic [IRQ_N-1:0] irqArmed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              irqArmed <= '0;
    else if (ctl.enterHalt) irqArmed <= ~irqReq;
  end
  logic [IRQ_N-1:0] irqFresh;
  assign irqFresh = irqReq & irqArmed;
  assign irqWake  = |irqFresh;
  assign vecOk    = (|(irqFresh & irqEn)) & ~stackFull;

  // cause flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toFlag <= 1'b0;
      pdFlag <= 1'b0;
    end else if (ctl.enterHalt) begin
      toFlag <= 1'b0;
      pdFlag <= 1'b1;
    end else if (ctl.extSleepHit) begin
      toFlag <= 1'b0;
      pdFlag <= 1'b1;
    end else if (ctl.wdtSleepHit) begin
      toFlag <= 1'b1;
      pdFlag <= 1'b1;
    end else if (ctl.wdtRunHit) begin
      toFlag <= 1'b1;
    end else if (ctl.clrPdf) begin
      pdFlag <= 1'b0;
    end
  end

  // start-up delay down-counter
  logic [CNT_W-1:0] holdCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          holdCnt <= HOLD_LOAD;
    else if (ctl.loadHold)              holdCnt <= HOLD_LOAD;
    else if (ctl.decHold && !holdDone)  holdCnt <= holdCnt - 1'b1;
  end
  assign holdDone = (holdCnt == '0);

endmodule

// File: rtl/sleep_wake_ctl.sv
module sleep_wake_ctl
  import sleep_wake_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   haltReq,
  input  logic   wdtClr,
  input  logic   extRst,
  input  logic   wdtOvf,
  input  logic   portWake,
  input  logic   irqWake,
  input  logic   vecOk,
  input  logic   holdDone,
  output dpCtl_t ctl,
  output logic   isRun,
  output logic   coldRst,
  output logic   warmRst,
  output logic   resumeNext,
  output logic   vectorIrq,
  output logic   holdStartup,
  output logic   extMemOff,
  output logic   wdtRestart
);

  seqState_t  state, nxtState;
  wakeCause_t cause, nxtCause;
  logic       anyWake;

  assign anyWake = extRst | wdtOvf | irqWake | portWake;

  always_comb begin
    nxtState = state;
    nxtCause = cause;
    ctl      = '0;
    unique case (state)
      ST_RUN: begin
        if (extRst) begin
          nxtState = ST_ISSUE;
          nxtCause = CAUSE_COLD;
        end else if (wdtOvf) begin
          ctl.wdtRunHit = 1'b1;
          nxtState      = ST_ISSUE;
          nxtCause      = CAUSE_COLD;
        end else if (haltReq) begin
          ctl.enterHalt = 1'b1;
          nxtState      = ST_SLEEP;
        end else if (wdtClr) begin
          ctl.clrPdf = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (extRst) begin
          ctl.extSleepHit = 1'b1;
          nxtCause        = CAUSE_COLD;
        end else if (wdtOvf) begin
          ctl.wdtSleepHit = 1'b1;
          nxtCause        = CAUSE_WARM;
        end else if (irqWake) begin
          nxtCause = vecOk ? CAUSE_VECTOR : CAUSE_RESUME;
        end else if (portWake) begin
          nxtCause = CAUSE_RESUME;
        end
        if (anyWake) begin
          ctl.loadHold = 1'b1;
          nxtState     = ST_HOLD;
        end
      end
      ST_HOLD: begin
        ctl.decHold = 1'b1;
        if (holdDone) nxtState = ST_ISSUE;
      end
      ST_ISSUE: nxtState = (cause == CAUSE_VECTOR) ? ST_VECT : ST_RUN;
      default:  nxtState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_HOLD;
      cause      <= CAUSE_COLD;
      wdtRestart <= 1'b0;
    end else begin
      state      <= nxtState;
      cause      <= nxtCause;
      wdtRestart <= ctl.enterHalt;
    end
  end

  assign isRun       = (state == ST_RUN);
  assign holdStartup = (state == ST_HOLD);
  assign extMemOff   = (state == ST_SLEEP);
  assign coldRst     = (state == ST_ISSUE) && (cause == CAUSE_COLD);
  assign warmRst     = (state == ST_ISSUE) && (cause == CAUSE_WARM);
  assign resumeNext  = (state == ST_ISSUE) && (cause == CAUSE_RESUME);
  assign vectorIrq   = (state == ST_VECT);

endmodule

// File: rtl/sleep_wake_top.sv
module sleep_wake_top
  import sleep_wake_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int IRQ_N    = 2,
  parameter int HOLD_CYC = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltReq,
  input  logic              wdtClr,
  input  logic              extRst,
  input  logic              wdtOvf,
  input  logic [IRQ_N-1:0]  irqReq,
  input  logic [IRQ_N-1:0]  irqEn,
  input  logic              stackFull,
  input  logic [PORT_W-1:0] portIn,
  input  logic [PORT_W-1:0] wakeMask,
  output logic              toFlag,
  output logic              pdFlag,
  output logic              coldRst,
  output logic              warmRst,
  output logic              holdStartup,
  output logic              resumeNext,
  output logic              vectorIrq,
  output logic              extMemOff,
  output logic              wdtRestart
);

  dpCtl_t ctl;
  logic   portWake, irqWake, vecOk, holdDone, isRun;

  sleep_wake_ctl u_ctl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .wdtClr(wdtClr),
    .extRst(extRst), .wdtOvf(wdtOvf), .portWake(portWake),
    .irqWake(irqWake), .vecOk(vecOk), .holdDone(holdDone), .ctl(ctl),
    .isRun(isRun), .coldRst(coldRst), .warmRst(warmRst),
    .resumeNext(resumeNext), .vectorIrq(vectorIrq),
    .holdStartup(holdStartup), .extMemOff(extMemOff),
    .wdtRestart(wdtRestart)
  );

  sleep_wake_dp #(
    .PORT_W(PORT_W), .IRQ_N(IRQ_N), .HOLD_CYC(HOLD_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .irqReq(irqReq), .irqEn(irqEn),
    .stackFull(stackFull), .portIn(portIn), .wakeMask(wakeMask),
    .portWake(portWake), .irqWake(irqWake), .vecOk(vecOk),
    .holdDone(holdDone), .toFlag(toFlag), .pdFlag(pdFlag)
  );

endmodule

// File: rtl/sleep_wake_chk.sv
module sleep_wake_chk #(
  parameter int HOLD_CYC = 1024
) (
  input logic clk,
  input logic rstN,
  input logic isRun,
  input logic haltReq,
  input logic wdtClr,
  input logic extRst,
  input logic wdtOvf,
  input logic toFlag,
  input logic pdFlag,
  input logic coldRst,
  input logic warmRst,
  input logic resumeNext,
  input logic vectorIrq,
  input logic holdStartup,
  input logic extMemOff,
  input logic wdtRestart
);

  localparam int RUN_W = $clog2(HOLD_CYC + 2) + 1;
  logic [RUN_W-1:0] holdRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdRun <= '0;
    else if (holdStartup) holdRun <= holdRun + 1'b1;
    else                  holdRun <= '0;
  end

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({coldRst, warmRst, resumeNext, vectorIrq}));

  // R1
  hold_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdStartup) |-> (holdRun == RUN_W'(HOLD_CYC)));

  // R2
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRun && haltReq && !extRst && !wdtOvf |=>
      pdFlag && !toFlag && extMemOff && wdtRestart);

  // R3
  clr_pdf_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRun && wdtClr && !haltReq && !extRst && !wdtOvf |=> !pdFlag && $stable(toFlag));

  // R4
  ext_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRun && extRst |=> coldRst && $stable(toFlag) && $stable(pdFlag));

  // R5
  wdt_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRun && !extRst && wdtOvf |=> coldRst && toFlag && $stable(pdFlag));

  // R7
  warm_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    warmRst |-> toFlag && pdFlag);

  // R9
  vector_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    vectorIrq |-> !holdStartup && $past(holdStartup, 2));

endmodule

bind sleep_wake_top sleep_wake_chk #(.HOLD_CYC(HOLD_CYC)) u_sleep_wake_chk (
  .clk(clk), .rstN(rstN), .isRun(isRun), .haltReq(haltReq),
  .wdtClr(wdtClr), .extRst(extRst), .wdtOvf(wdtOvf), .toFlag(toFlag),
  .pdFlag(pdFlag), .coldRst(coldRst), .warmRst(warmRst),
  .resumeNext(resumeNext), .vectorIrq(vectorIrq),
  .holdStartup(holdStartup), .extMemOff(extMemOff), .wdtRestart(wdtRestart)
);

// File: tb/test_sleep_wake_top.sv
module test_sleep_wake_top;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 1024;
  localparam int WD_LIMIT   = 60000;

  localparam int K_COLD = 0, K_WARM = 1, K_RESUME = 2, K_VECTOR = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       haltReq = 1'b0, wdtClr = 1'b0, extRst = 1'b0, wdtOvf = 1'b0;
  logic [1:0] irqReq = '0, irqEn = '0;
  logic       stackFull = 1'b0;
  logic [7:0] portIn = 8'hFF, wakeMask = 8'hFF;
  logic       toFlag, pdFlag, coldRst, warmRst, holdStartup;
  logic       resumeNext, vectorIrq, extMemOff, wdtRestart;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sleep_wake_top i_sleep_wake_top (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .wdtClr(wdtClr),
    .extRst(extRst), .wdtOvf(wdtOvf), .irqReq(irqReq), .irqEn(irqEn),
    .stackFull(stackFull), .portIn(portIn), .wakeMask(wakeMask),
    .toFlag(toFlag), .pdFlag(pdFlag), .coldRst(coldRst), .warmRst(warmRst),
    .holdStartup(holdStartup), .resumeNext(resumeNext),
    .vectorIrq(vectorIrq), .extMemOff(extMemOff), .wdtRestart(wdtRestart)
  );

  typedef struct {
    string req;
    int    kind;
    int    to;
    int    pd;
    int    holdLen;
    int    gap;   // -1: not checked
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expectStrobe(string req, int kind, int to, int pd, int holdLen, int gap);
    expItem_t e;
    e.req = req; e.kind = kind; e.to = to; e.pd = pd;
    e.holdLen = holdLen; e.gap = gap;
    expQ.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    tick(3);
  endtask

  task automatic doHalt();
    @(negedge clk) haltReq = 1'b1;
    @(negedge clk) haltReq = 1'b0;
  endtask

  // monitor: pops one expected item per outcome strobe
  initial begin
    int holdCnt = 0;
    int gap = 0;
    forever begin
      @(negedge clk);
      #2;
      if (rstN && !done) begin
        if (holdStartup) begin holdCnt++; gap = 0; end
        else gap++;
        if (coldRst | warmRst | resumeNext | vectorIrq) begin
          int kind;
          expItem_t e;
          kind = coldRst ? K_COLD : warmRst ? K_WARM : resumeNext ? K_RESUME : K_VECTOR;
          chk("R12", "strobes high together",
              int'(coldRst) + int'(warmRst) + int'(resumeNext) + int'(vectorIrq), 1);
          if (expQ.size() == 0) begin
            chk("R12", "unexpected strobe kind", kind, -1);
          end else begin
            e = expQ.pop_front();
            chk(e.req, "strobe kind", kind, e.kind);
            chk(e.req, "toFlag", int'(toFlag), e.to);
            chk(e.req, "pdFlag", int'(pdFlag), e.pd);
            chk(e.req, "hold cycles", holdCnt, e.holdLen);
            if (e.gap >= 0) chk(e.req, "cycles after hold", gap, e.gap);
          end
          holdCnt = 0;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog R1..: actual=%0d expected=done", WD_LIMIT);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    // R1 power-up
    #2;
    chk("R1", "toFlag in reset", int'(toFlag), 0);
    chk("R1", "pdFlag in reset", int'(pdFlag), 0);
    expectStrobe("R1", K_COLD, 0, 0, HOLD, 1);
    tick(3);
    rstN = 1'b1;
    drain();

    // R2 sleep entry
    doHalt();
    #2;
    chk("R2", "extMemOff", int'(extMemOff), 1);
    chk("R2", "wdtRestart", int'(wdtRestart), 1);
    chk("R2", "pdFlag", int'(pdFlag), 1);
    chk("R2", "toFlag", int'(toFlag), 0);
    tick(1); #2;
    chk("R2", "wdtRestart single cycle", int'(wdtRestart), 0);

    // R8 masked pin ignored, enabled pin wakes
    wakeMask = 8'h0F;
    portIn[7] = 1'b0;
    tick(8); #2;
    chk("R8", "asleep after masked fall", int'(extMemOff), 1);
    chk("R8", "no hold after masked fall", int'(holdStartup), 0);
    expectStrobe("R8", K_RESUME, 0, 1, HOLD, 1);
    @(negedge clk) portIn[2] = 1'b0;
    drain();
    portIn = 8'hFF;
    tick(4);

    // R3 clear watchdog
    @(negedge clk) wdtClr = 1'b1;
    @(negedge clk) wdtClr = 1'b0;
    #2;
    chk("R3", "pdFlag cleared", int'(pdFlag), 0);
    chk("R3", "toFlag unchanged", int'(toFlag), 0);

    // R10 pending request at entry, then R9 vectored wake
    irqReq = 2'b01;
    irqEn  = 2'b10;
    doHalt();
    tick(8); #2;
    chk("R10", "asleep with pending request", int'(extMemOff), 1);
    expectStrobe("R9", K_VECTOR, 0, 1, HOLD, 2);
    @(negedge clk) irqReq = 2'b11;
    drain();
    irqReq = '0;

    // R9 stack full -> resume
    irqEn = 2'b11;
    stackFull = 1'b1;
    doHalt();
    expectStrobe("R9", K_RESUME, 0, 1, HOLD, 1);
    @(negedge clk) irqReq = 2'b01;
    drain();
    irqReq = '0;
    stackFull = 1'b0;

    // R9 interrupt disabled -> resume
    irqEn = 2'b00;
    doHalt();
    expectStrobe("R9", K_RESUME, 0, 1, HOLD, 1);
    @(negedge clk) irqReq = 2'b10;
    drain();
    irqReq = '0;

    // R7 watchdog wake from sleep
    doHalt();
    expectStrobe("R7", K_WARM, 1, 1, HOLD, 1);
    @(negedge clk) wdtOvf = 1'b1;
    @(negedge clk) wdtOvf = 1'b0;
    drain();

    // R4 external reset during run
    expectStrobe("R4", K_COLD, 1, 1, 0, -1);
    @(negedge clk) extRst = 1'b1;
    @(negedge clk) extRst = 1'b0;
    #2;
    chk("R4", "no hold", int'(holdStartup), 0);
    drain();

    // R6 external reset during sleep
    doHalt();
    expectStrobe("R6", K_COLD, 0, 1, HOLD, 1);
    @(negedge clk) extRst = 1'b1;
    @(negedge clk) extRst = 1'b0;
    drain();

    // R5 watchdog overflow during run
    expectStrobe("R5", K_COLD, 1, 1, 0, -1);
    @(negedge clk) wdtOvf = 1'b1;
    @(negedge clk) wdtOvf = 1'b0;
    drain();

    // R11 all causes at once: external reset wins
    irqEn = 2'b11;
    wakeMask = 8'hFF;
    doHalt();
    expectStrobe("R11", K_COLD, 0, 1, HOLD, 1);
    @(negedge clk) begin extRst = 1'b1; wdtOvf = 1'b1; irqReq = 2'b01; portIn[0] = 1'b0; end
    @(negedge clk) begin extRst = 1'b0; wdtOvf = 1'b0; end
    drain();
    irqReq = '0; portIn = 8'hFF;
    tick(4);

    // R11 watchdog beats interrupt and port
    doHalt();
    expectStrobe("R11", K_WARM, 1, 1, HOLD, 1);
    @(negedge clk) begin wdtOvf = 1'b1; irqReq = 2'b01; portIn[1] = 1'b0; end
    @(negedge clk) wdtOvf = 1'b0;
    drain();
    irqReq = '0; portIn = 8'hFF;
    tick(4);

    // R11 interrupt beats port (vector chosen, not plain resume)
    doHalt();
    expectStrobe("R11", K_VECTOR, 0, 1, HOLD, 2);
    @(negedge clk) begin irqReq = 2'b10; portIn[3] = 1'b0; end
    drain();
    irqReq = '0; portIn = 8'hFF;
    tick(4);

    chk("R12", "expected strobes left", expQ.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule